// File: doc/BRIEF.md
# Multi-cycle 8-bit accumulator processor

This block is a compact, non-pipelined 8-bit soft processor. All arithmetic goes through one accumulator. A bank of sixteen 8-bit registers supplies the second operand and receives copies of the accumulator. Register 11 also serves as the base for indexed data accesses. The core drives a 12-bit address into a 16-bit program memory and a 12-bit address into an 8-bit data memory. Both memories sit outside the block and are synchronous: each one returns read data one clock edge after the address is presented. A data write takes effect on the clock edge where the write strobe is high.

Every instruction is one 16-bit word in one of three layouts:
- Address form: opcode in [15:12], a 12-bit target in [11:0].
- Register form: opcode in [15:12], sub-operation in [11:8], a secondary field in [7:4] and a register number in [3:0].
- Immediate form: opcode in [15:12], sub-operation in [11:8], an 8-bit constant in [7:0].

Most instructions spend one fetch cycle and one execute cycle. Indexed loads and stores add two memory cycles. There is one link register for subroutine calls. There is also one level of interrupt, with its own return register and an enable bit.

Top module: `acc8_core`

## Requirements
- R1: While and after reset, the first fetch is from address 0, and the accumulator, the flag and the interrupt enable are all 0. The interrupt enable stays 0 until an enable instruction runs, even if `irq` is held high.
- R2: Opcode map on [15:12]:
  - 0 loads data memory at [11:0] into the accumulator; 1 stores the accumulator there; 2 jumps; 3 jumps if the flag is 1; 4 jumps if the flag is 0; 5 calls; 6 loads [7:0] into the accumulator.
  - 7 is the register group and 8 is the immediate group, both decoded by [11:8]. 9 is the system group: [11:8] = 0 returns from interrupt, 1 enables interrupts, 2 disables them.
  - Opcodes 10 to 15 and unused sub-operation codes change nothing.
- R3: Each instruction except indexed load and store occupies exactly 2 cycles, fetch then execute. Indexed load and store occupy 4 cycles.
- R4: A store asserts `dm_we` for the single execute cycle, with the accumulator on `dm_wdata`. A load's value is in the accumulator when the next instruction executes.
- R5: Sub-operation codes shared by both groups: 3 add, 4 subtract, 5 AND, 6 OR, 7 XOR. The operand is register [3:0] in group 7 and the constant [7:0] in group 8. The result goes to the accumulator modulo 256.
- R6: Sub-operation codes 8 to 12 are equal, below, below-or-equal, above and above-or-equal. They compare the accumulator, unsigned, against the operand and write only the flag.
- R7: In group 7, sub-operation 13 copies the accumulator to register [3:0] and 14 copies register [3:0] to the accumulator. Sub-operation 15 inverts the accumulator when [7:4] = 0 and clears register [3:0] when [7:4] = 1.
- R8: In group 7, sub-operation 1 is the indexed load and 2 is the indexed store. The data address is {R11, 4'b0000} + register [3:0], taken modulo 4096. The store strobe comes in the third cycle and the loaded value lands in the fourth.
- R9: A call saves the address after the call in one link register. Group-7 sub-operation 0 jumps to the link. A second call overwrites the link.
- R10: When `irq` is high and interrupts are enabled at a fetch boundary, the block spends that one cycle saving PC to the interrupt return register. It then continues at address 0x001 with interrupts disabled, so a held request does not re-enter.
- R11: Return-from-interrupt restores the saved PC and re-enables interrupts. The disable instruction blocks a later request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq | input | 1 | Level-sensitive interrupt request |
| pm_addr | output | 12 | Program memory address (current PC) |
| pm_data | input | 16 | Program word, registered one edge after `pm_addr` |
| dm_addr | output | 12 | Data memory address |
| dm_wdata | output | 8 | Data memory write value (accumulator) |
| dm_we | output | 1 | Data memory write strobe |
| dm_rdata | input | 8 | Data memory read value, registered one edge after `dm_addr` |

## Verification
Counting from the fetch cycle of an instruction, a direct store's strobe is due in its second cycle and an indexed store's strobe in its third. A direct load's value must be usable by the very next instruction, and an indexed load's value one cycle after the indexed store's strobe slot. Interrupt entry adds a single cycle before the handler's fetch. The bench releases reset on a falling edge and samples the ports on later falling edges. It counts those edges to the first write strobe, so each cycle total is checked exactly. Functional results are read from the data memory only after a fixed run window that is longer than any test program.

// File: rtl/acc8_core.sv
module acc8_core #(
  parameter int          BP_SEL  = 11,
  parameter logic [11:0] IRQ_VEC = 12'h001
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        irq,
  output logic [11:0] pm_addr,
  input  logic [15:0] pm_data,
  output logic [11:0] dm_addr,
  output logic [7:0]  dm_wdata,
  output logic        dm_we,
  input  logic [7:0]  dm_rdata
);
  localparam logic [3:0] OP_LDA = 4'h0, OP_STA = 4'h1, OP_JMP = 4'h2, OP_JT = 4'h3,
                         OP_JF = 4'h4, OP_CALL = 4'h5, OP_LCA = 4'h6, OP_REG = 4'h7,
                         OP_IMM = 4'h8, OP_SYS = 4'h9;
  localparam logic [3:0] X_RET = 4'h0, X_LDX = 4'h1, X_STX = 4'h2, X_ADD = 4'h3,
                         X_SUB = 4'h4, X_AND = 4'h5, X_OR = 4'h6, X_XOR = 4'h7,
                         X_EQ = 4'h8, X_LT = 4'h9, X_LE = 4'hA, X_GT = 4'hB,
                         X_GE = 4'hC, X_MOV = 4'hD, X_MVA = 4'hE, X_MISC = 4'hF;
  localparam logic [3:0] S_RETI = 4'h0, S_EI = 4'h1, S_DI = 4'h2;

  typedef enum logic [1:0] {S_FETCH, S_EXEC, S_MEM1, S_MEM2} st_t;
  st_t st;

  logic [11:0] pc, link, ipc, ea;
  logic [7:0]  acc;
  logic [7:0]  regs [16];
  logic        flag, ie, ld_pend;
  logic [15:0] ir;

  logic [15:0] inst;
  logic [3:0]  op, xop, rs1, rs2;
  logic [7:0]  rval, opnd, alu_res;
  logic        cmp_res, ex, take, alu_sel, cmp_sel;
  logic [11:0] ea_next;

  assign inst    = (st == S_EXEC) ? pm_data : ir;
  assign op      = inst[15:12];
  assign xop     = inst[11:8];
  assign rs1     = inst[7:4];
  assign rs2     = inst[3:0];
  assign rval    = regs[rs2];
  assign opnd    = (op == OP_IMM) ? inst[7:0] : rval;
  assign ex      = (st == S_EXEC);
  assign take    = (st == S_FETCH) && irq && ie;
  assign ea_next = {regs[BP_SEL], 4'h0} + {4'h0, rval};
  assign alu_sel = (xop >= X_ADD) && (xop <= X_XOR);
  assign cmp_sel = (xop >= X_EQ) && (xop <= X_GE);

  always_comb begin
    case (xop)
      X_ADD:   alu_res = acc + opnd;
      X_SUB:   alu_res = acc - opnd;
      X_AND:   alu_res = acc & opnd;
      X_OR:    alu_res = acc | opnd;
      X_XOR:   alu_res = acc ^ opnd;
      default: alu_res = acc;
    endcase
    case (xop)
      X_EQ:    cmp_res = (acc == opnd);
      X_LT:    cmp_res = (acc <  opnd);
      X_LE:    cmp_res = (acc <= opnd);
      X_GT:    cmp_res = (acc >  opnd);
      X_GE:    cmp_res = (acc >= opnd);
      default: cmp_res = 1'b0;
    endcase
  end

  assign pm_addr  = pc;
  assign dm_addr  = (st == S_MEM1 || st == S_MEM2) ? ea : inst[11:0];
  assign dm_wdata = acc;
  assign dm_we    = (ex && op == OP_STA) || (st == S_MEM1 && xop == X_STX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_FETCH; pc <= '0; acc <= '0; flag <= 1'b0; ie <= 1'b0;
      link <= '0; ipc <= '0; ea <= '0; ir <= '0; ld_pend <= 1'b0;
      for (int i = 0; i < 16; i++) regs[i] <= '0;
    end else begin
      case (st)
        S_FETCH: begin
          if (ld_pend) acc <= dm_rdata;
          ld_pend <= 1'b0;
          if (take) begin
            ipc <= pc; pc <= IRQ_VEC; ie <= 1'b0;
          end else begin
            pc <= pc + 12'd1; st <= S_EXEC;
          end
        end
        S_EXEC: begin
          ir <= pm_data;
          st <= S_FETCH;
          case (op)
            OP_LDA:  ld_pend <= 1'b1;
            OP_JMP:  pc <= inst[11:0];
            OP_JT:   if (flag)  pc <= inst[11:0];
            OP_JF:   if (!flag) pc <= inst[11:0];
            OP_CALL: begin link <= pc; pc <= inst[11:0]; end
            OP_LCA:  acc <= inst[7:0];
            OP_REG: begin
              if (alu_sel) acc <= alu_res;
              if (cmp_sel) flag <= cmp_res;
              case (xop)
                X_RET:        pc <= link;
                X_LDX, X_STX: begin ea <= ea_next; st <= S_MEM1; end
                X_MOV:        regs[rs2] <= acc;
                X_MVA:        acc <= rval;
                X_MISC: begin
                  if (rs1 == 4'h0) acc <= ~acc;
                  else if (rs1 == 4'h1) regs[rs2] <= '0;
                end
                default: ;
              endcase
            end
            OP_IMM: begin
              if (alu_sel) acc <= alu_res;
              if (cmp_sel) flag <= cmp_res;
            end
            OP_SYS: begin
              case (xop)
                S_RETI: begin pc <= ipc; ie <= 1'b1; end
                S_EI:   ie <= 1'b1;
                S_DI:   ie <= 1'b0;
                default: ;
              endcase
            end
            default: ;
          endcase
        end
        S_MEM1: st <= S_MEM2;
        default: begin
          if (xop == X_LDX) acc <= dm_rdata;
          st <= S_FETCH;
        end
      endcase
    end
  end

  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    dm_we |=> !dm_we); // R4
  AST_TWO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ex && !(op == OP_REG && (xop == X_LDX || xop == X_STX))) |=> st == S_FETCH); // R3
  AST_IDX_MEM1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_MEM1) |=> st == S_MEM2); // R8
  AST_IDX_MEM2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_MEM2) |=> st == S_FETCH); // R3
  AST_IRQ_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (pc == IRQ_VEC && !ie && st == S_FETCH)); // R10
  AST_RET_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    (ex && op == OP_REG && xop == X_RET) |=> pc == $past(link)); // R9
  AST_RETI_IE: assert property (@(posedge clk) disable iff (!rst_n)
    (ex && op == OP_SYS && xop == S_RETI) |=> (ie && pc == $past(ipc))); // R11
endmodule

// File: tb/tb_acc8_core.sv
`timescale 1ns/1ps
module tb_acc8_core;
  logic clk = 1'b0, rst_n = 1'b0, irq = 1'b0;
  logic [11:0] pm_addr, dm_addr;
  logic [15:0] pm_data;
  logic [7:0]  dm_wdata, dm_rdata;
  logic        dm_we;
  logic [15:0] prog  [256];
  logic [7:0]  dmem  [256];
  logic [7:0]  dinit [256];
  logic [11:0] last_wa;
  logic irq_lvl = 1'b0, irq_mode = 1'b0;
  int total = 0, bad = 0, p = 0;

  always #4 clk = ~clk;

  acc8_core dut (.clk(clk), .rst_n(rst_n), .irq(irq), .pm_addr(pm_addr), .pm_data(pm_data),
                 .dm_addr(dm_addr), .dm_wdata(dm_wdata), .dm_we(dm_we), .dm_rdata(dm_rdata));

  always @(posedge clk) begin
    pm_data  <= prog[pm_addr[7:0]];
    dm_rdata <= dmem[dm_addr[7:0]];
    if (!rst_n) dmem <= dinit;
    else if (dm_we) begin dmem[dm_addr[7:0]] <= dm_wdata; last_wa <= dm_addr; end
  end

  always @(negedge clk) begin
    if (!irq_mode) irq <= irq_lvl;
    else if (dm_we && dm_addr == 12'h093) irq <= 1'b0;
    else if (dm_we && dm_addr == 12'h091) irq <= 1'b1;
  end

  function automatic logic [15:0] wl(input logic [3:0] o, input logic [11:0] a); return {o, a}; endfunction
  function automatic logic [15:0] wr(input logic [3:0] x, input logic [3:0] a, input logic [3:0] b); return {4'h7, x, a, b}; endfunction
  function automatic logic [15:0] wi(input logic [3:0] x, input logic [7:0] d); return {4'h8, x, d}; endfunction
  function automatic logic [15:0] lca(input logic [7:0] d); return {4'h6, 4'h0, d}; endfunction
  function automatic logic [15:0] sta(input logic [11:0] a); return {4'h1, a}; endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin bad++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic put(input logic [15:0] w); prog[p] = w; p++; endtask
  task automatic park(); put(wl(4'h2, 12'(p))); endtask

  task automatic clear();
    rst_n = 1'b0; irq_mode = 1'b0; irq_lvl = 1'b0; p = 0;
    for (int i = 0; i < 256; i++) begin prog[i] = 16'hA000; dinit[i] = 8'h00; end
  endtask

  task automatic boot(output int first_we);
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; first_we = -1;
    for (int c = 0; c < 300; c++) begin
      #1; if (dm_we && first_we < 0) first_we = c;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    int w;
    clear();
    put(wl(4'h2, 12'h008));
    put(lca(8'hEE)); put(sta(12'h012)); park();
    p = 8;
    put(sta(12'h010)); put(wl(4'h3, 12'h00C)); put(lca(8'h11)); put(sta(12'h011)); park();
    dinit[8'h10] = 8'hFF; irq_lvl = 1'b1;
    repeat (3) @(posedge clk); @(negedge clk);
    chk("R1 pm_addr in reset", pm_addr, 0);
    chk("R1 dm_we in reset", dm_we, 0);
    boot(w);
    chk("R1 acc zero", dmem[8'h10], 0);
    chk("R1 flag zero", dmem[8'h11], 8'h11);
    chk("R1 irq disabled", dmem[8'h12], 0);
  endtask

  task automatic t_timing();
    int w;
    clear(); put(lca(8'h05)); put(sta(12'h020)); park(); boot(w);
    chk("R3 two-cycle store slot", w, 3);
    clear(); put(lca(8'h05)); put(wr(4'h1, 0, 0)); put(sta(12'h020)); park(); boot(w);
    chk("R3 ldx four cycles", w, 7);
    clear(); put(lca(8'h05)); put(wr(4'h2, 0, 0)); park(); boot(w);
    chk("R8 stx strobe third cycle", w, 4);
    clear(); put(lca(8'h05)); put(16'hA000); put(sta(12'h020)); park(); boot(w);
    chk("R2 undefined op two cycles", w, 5);
    chk("R2 undefined op keeps acc", dmem[8'h20], 5);
  endtask

  task automatic t_ldst();
    int w;
    clear();
    put(lca(8'h02)); put(wr(4'hD, 0, 11)); put(lca(8'h05)); put(wr(4'hD, 0, 3));
    put(wr(4'h1, 0, 3)); put(sta(12'h040));
    put(lca(8'h07)); put(wr(4'hD, 0, 4)); put(lca(8'h77)); put(wr(4'h2, 0, 4));
    put(wl(4'h0, 12'h030)); put(sta(12'h041));
    put(lca(8'h03)); put(wr(4'hD, 0, 11)); put(lca(8'hF5)); put(wr(4'hD, 0, 5));
    put(lca(8'hC1)); put(wr(4'h2, 0, 5)); park();
    dinit[8'h25] = 8'h5A; dinit[8'h30] = 8'h3C;
    boot(w);
    chk("R8 ldx value", dmem[8'h40], 8'h5A);
    chk("R8 stx value", dmem[8'h27], 8'h77);
    chk("R4 lda then sta", dmem[8'h41], 8'h3C);
    chk("R8 carry into upper address", last_wa, 12'h125);
    chk("R8 stx carry value", dmem[8'h25], 8'hC1);
  endtask

  task automatic t_alu();
    int w;
    clear();
    put(lca(8'hF0)); put(wi(4'h3, 8'h20)); put(sta(12'h050));
    put(lca(8'h0F)); put(wr(4'hD, 0, 1)); put(lca(8'h03)); put(wr(4'h4, 0, 1)); put(sta(12'h051));
    put(wi(4'h5, 8'h3C)); put(wi(4'h6, 8'h81)); put(wi(4'h7, 8'hFF)); put(sta(12'h052));
    put(lca(8'h55)); put(wr(4'hD, 0, 2)); put(lca(8'h0F)); put(wr(4'h5, 0, 2));
    put(wr(4'h6, 0, 1)); put(wr(4'h7, 0, 2)); put(wr(4'h3, 0, 1)); put(wi(4'h4, 8'h70));
    put(sta(12'h053)); park();
    boot(w);
    chk("R5 addi wrap", dmem[8'h50], 8'h10);
    chk("R5 sub borrow", dmem[8'h51], 8'hF4);
    chk("R5 imm logic chain", dmem[8'h52], 8'h4A);
    chk("R5 reg logic chain", dmem[8'h53], 8'hF9);
  endtask

  task automatic flagblk(input logic [7:0] a, input logic [15:0] cw, input logic [7:0] slot, input bit use_jt);
    put(lca(a)); put(cw);
    put(wl(use_jt ? 4'h3 : 4'h4, 12'(p + 3)));
    put(lca(use_jt ? 8'h02 : 8'h01)); put(sta({4'h0, slot}));
  endtask

  task automatic t_cmp();
    int w;
    logic [7:0] exp [12] = '{1, 0, 1, 1, 0, 1, 0, 1, 1, 0, 2, 0};
    clear();
    put(lca(8'h80)); put(wr(4'hD, 0, 5));
    flagblk(8'h10, wr(4'h9, 0, 5), 8'h60, 0);
    flagblk(8'h10, wr(4'hB, 0, 5), 8'h61, 0);
    flagblk(8'h80, wr(4'h8, 0, 5), 8'h62, 0);
    flagblk(8'h80, wr(4'hA, 0, 5), 8'h63, 0);
    flagblk(8'h7F, wr(4'hC, 0, 5), 8'h64, 0);
    flagblk(8'h33, wi(4'h8, 8'h33), 8'h65, 0);
    flagblk(8'h33, wi(4'h9, 8'h33), 8'h66, 0);
    flagblk(8'h33, wi(4'hA, 8'h33), 8'h67, 0);
    flagblk(8'hF0, wi(4'hB, 8'h20), 8'h68, 0);
    flagblk(8'hF0, wi(4'hC, 8'hF1), 8'h69, 0);
    flagblk(8'h01, wi(4'h8, 8'h00), 8'h6A, 1);
    flagblk(8'h01, wi(4'h8, 8'h01), 8'h6B, 1);
    park();
    boot(w);
    for (int k = 0; k < 12; k++) chk($sformatf("R6 compare/branch case %0d", k), dmem[8'h60 + k], exp[k]);
  endtask

  task automatic t_regs();
    int w;
    clear();
    put(lca(8'h9C)); put(16'hB5A5); put(wr(4'hD, 0, 7)); put(lca(8'h00)); put(wr(4'hE, 0, 7)); put(sta(12'h070));
    put(wr(4'hF, 1, 7)); put(wr(4'hE, 0, 7)); put(sta(12'h071));
    put(lca(8'h3C)); put(wr(4'hF, 0, 0)); put(sta(12'h072));
    put(lca(8'hAB)); put(wr(4'hD, 0, 14)); put(lca(8'h00)); put(wr(4'hE, 0, 14)); put(sta(12'h073));
    park();
    dinit[8'h71] = 8'hFF;
    boot(w);
    chk("R7 mov/mva", dmem[8'h70], 8'h9C);
    chk("R7 clr", dmem[8'h71], 8'h00);
    chk("R7 not", dmem[8'h72], 8'hC3);
    chk("R7 special register", dmem[8'h73], 8'hAB);
  endtask

  task automatic t_call();
    int w;
    clear();
    put(wl(4'h5, 12'h010)); put(sta(12'h080)); put(lca(8'h44)); put(wl(4'h5, 12'h020)); put(sta(12'h081)); park();
    p = 16; put(lca(8'h11)); put(wr(4'h0, 0, 0));
    p = 32; put(lca(8'h22)); put(wl(4'h5, 12'h030)); put(sta(12'h082)); park();
    p = 48; put(wi(4'h3, 8'h01)); put(wr(4'h0, 0, 0));
    boot(w);
    chk("R9 return to caller", dmem[8'h80], 8'h11);
    chk("R9 link overwritten", dmem[8'h82], 8'h23);
    chk("R9 outer return lost", dmem[8'h81], 8'h00);
  endtask

  task automatic t_irq();
    int w;
    clear();
    put(wl(4'h2, 12'h010));
    put(wr(4'hD, 0, 9)); put(sta(12'h090)); put(wl(4'h0, 12'h093)); put(wi(4'h3, 8'h01));
    put(sta(12'h093)); put(wr(4'hE, 0, 9)); put({4'h9, 4'h0, 8'h00});
    p = 16;
    put(lca(8'h31)); put({4'h9, 4'h1, 8'h00}); put(wi(4'h3, 8'h01)); put({4'h9, 4'h2, 8'h00});
    put(sta(12'h091)); put(lca(8'h77)); put(sta(12'h094)); park();
    irq_lvl = 1'b1; @(negedge clk); @(negedge clk); irq_mode = 1'b1;
    boot(w);
    chk("R10 entry after ei", dmem[8'h90], 8'h31);
    chk("R10 no re-entry", dmem[8'h93], 8'h01);
    chk("R11 reti resumes", dmem[8'h91], 8'h32);
    chk("R11 di blocks", dmem[8'h94], 8'h77);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset(); t_timing(); t_ldst(); t_alu(); t_cmp(); t_regs(); t_call(); t_irq();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule